// File: doc/BRIEF.md
# Sequential DTMF Address Matcher

This block sits behind an external tone detector. Each time the detector recognises a tone pair, it raises a strobe and presents a 4-bit code. The matcher compares these codes against a programmed address of several digits. The digits must arrive in a fixed order, and each must come within a selectable interval after the previous one. When the whole address has been received, the block raises a correct-address output for a bounded time.

Timing comes from a binary divider chain inside the block. The chain advances on a slow one-clock-wide tick. The chain is restarted by every accepted digit and is held at zero while a matched tone is still sounding. One selectable tap of this chain sets two things: the longest allowed gap between digits, and the moment the output turns off again. A second selectable tap sets how long after completion the output may first turn on.

The strobe, the code lines and an external reset request are asynchronous to the system clock. All three pass through the same two-flop synchroniser, so they arrive together.

Top module: `dtmf_addr_matcher`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `step_dbg` is 0 and `addr_ok` is 0.
- R2: `step_dbg` value k (0 to 3) means the block is waiting for programmed digit k+1, which is held in `prog_digits[4k+3:4k]`. A received code matches only when all 4 bits equal that digit. `step_dbg` never exceeds 4 and only increases in steps of one.
- R3: A received code that differs from the current programmed digit in any bit returns `step_dbg` to 0.
- R4: A matching code does not change `step_dbg` while its strobe is high. The step advances by one only after the strobe falls.
- R5: In steps 1 to 3, if no matching tone begins within 2^`tmo_sel` ticks after the last advance, `step_dbg` returns to 0.
- R6: When the fourth digit ends, `step_dbg` becomes 4 (complete). `addr_ok` is high only while `step_dbg` is 4.
- R7: Entering the complete step restarts the divider. `addr_ok` is high from 2^`delay_sel` ticks to 2^`tmo_sel` ticks after entry, which is (2^tmo_sel − 2^delay_sel) ticks, or never if `delay_sel` ≥ `tmo_sel`. After that, `step_dbg` returns to 0.
- R8: A strobe received in the complete step is ignored. It neither advances the step nor restarts the interval, so the active time of `addr_ok` is unchanged.
- R9: A synchronised `ext_reset_in` returns `step_dbg` to 0. It wins over a matched tone ending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Slow timebase enable, one clock wide |
| strobe_in | input | 1 | Tone-valid strobe from the detector (asynchronous) |
| code_in | input | CODE_W | Received digit code (asynchronous, stable while strobe high) |
| prog_digits | input | DIGITS*CODE_W | Programmed address; digit k+1 at bits [CODE_W*k +: CODE_W] |
| ext_reset_in | input | 1 | External sequence reset request (asynchronous) |
| tmo_sel | input | TAP_W | Divider tap for the interdigit timeout and output-off time |
| delay_sel | input | TAP_W | Divider tap for the output enable delay |
| addr_ok | output | 1 | Correct-address output |
| step_dbg | output | STEP_W | Current sequence step (0..DIGITS) |

## Verification
The strobe and the external reset request pass through synchronisers of equal depth. A released matched tone and a reset request can therefore reach the sequencer in the same cycle. The bench provokes this by dropping the strobe of a correct second digit and pulsing the reset request for one clock on the same falling edge. The result must be step 0, with no advance left behind. The bench also sweeps both tap selects and compares the measured active time with the arithmetic expectation. It delivers a valid first digit while the block is in the complete step and checks that this changes nothing.

// File: rtl/dam_pkg.sv
package dam_pkg;
   typedef enum logic [1:0] {
      EV_IDLE    = 2'd0,
      EV_HIT     = 2'd1,
      EV_MISS    = 2'd2,
      EV_ADVANCE = 2'd3
   } dam_ev_e;
endpackage

// File: rtl/dam_sync.sv
module dam_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dam_divider.sv
module dam_divider #(
   parameter int BITS = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clr,
   output logic [BITS-1:0] count
);
   logic [BITS:0] carry;
   assign carry[0] = tick;

   for (genvar b = 0; b < BITS; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)        bit_q <= 1'b0;
         else if (clr)      bit_q <= 1'b0;
         else if (carry[b]) bit_q <= ~bit_q;
      assign count[b]    = bit_q;
      assign carry[b+1]  = carry[b] & bit_q;
   end
endmodule

// File: rtl/dam_seq.sv
module dam_seq
   import dam_pkg::*;
#(
   parameter int DIGITS = 4,
   parameter int CODE_W = 4,
   parameter int STEP_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_all,
   input  logic                     rise,
   input  logic                     fall,
   input  logic [CODE_W-1:0]        code,
   input  logic [DIGITS*CODE_W-1:0] prog,
   input  logic                     expired,
   output logic [STEP_W-1:0]        step_q,
   output logic                     held_q,
   output logic                     div_clr
);
   localparam logic [STEP_W-1:0] DONE = STEP_W'(DIGITS);

   logic [CODE_W-1:0] want;
   dam_ev_e           ev;

   always_comb begin
      want = '0;
      for (int i = 0; i < DIGITS; i++)
         if (step_q == STEP_W'(i)) want = prog[i*CODE_W +: CODE_W];
   end

   always_comb begin
      ev = EV_IDLE;
      if (step_q != DONE) begin
         if (rise)                ev = (code == want) ? EV_HIT : EV_MISS;
         else if (fall && held_q) ev = EV_ADVANCE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         held_q <= 1'b0;
      end else if (clr_all) begin
         step_q <= '0;
         held_q <= 1'b0;
      end else if (step_q == DONE) begin
         if (expired) step_q <= '0;
      end else begin
         case (ev)
            EV_HIT:  held_q <= 1'b1;
            EV_MISS: begin
               step_q <= '0;
               held_q <= 1'b0;
            end
            EV_ADVANCE: begin
               step_q <= step_q + 1'b1;
               held_q <= 1'b0;
            end
            default:
               if (!held_q && step_q != '0 && expired) step_q <= '0;
         endcase
      end
   end

   assign div_clr = clr_all | held_q | (ev == EV_HIT) | (ev == EV_ADVANCE);
endmodule

// File: rtl/dtmf_addr_matcher.sv
module dtmf_addr_matcher #(
   parameter int DIGITS      = 4,
   parameter int CODE_W      = 4,
   parameter int DIV_BITS    = 12,
   parameter int SYNC_STAGES = 2,
   localparam int TAP_W      = $clog2(DIV_BITS),
   localparam int STEP_W     = $clog2(DIGITS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_in,
   input  logic                     strobe_in,
   input  logic [CODE_W-1:0]        code_in,
   input  logic [DIGITS*CODE_W-1:0] prog_digits,
   input  logic                     ext_reset_in,
   input  logic [TAP_W-1:0]         tmo_sel,
   input  logic [TAP_W-1:0]         delay_sel,
   output logic                     addr_ok,
   output logic [STEP_W-1:0]        step_dbg
);
   localparam int SYNC_W = CODE_W + 2;
   localparam logic [STEP_W-1:0] DONE = STEP_W'(DIGITS);

   if (DIGITS < 1)      begin : g_bad_digits $error("DIGITS must be at least 1"); end
   if (CODE_W < 1)      begin : g_bad_code   $error("CODE_W must be at least 1"); end
   if (DIV_BITS < 2)    begin : g_bad_div    $error("DIV_BITS must be at least 2"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync   $error("SYNC_STAGES must be at least 2"); end

   logic              ext_sync;
   logic              strobe_sync;
   logic              strobe_prev;
   logic [CODE_W-1:0] code_sync;
   logic              strobe_rise;
   logic              strobe_fall;
   logic [DIV_BITS-1:0] count;
   logic              expired;
   logic              delay_met;
   logic              div_clr;
   logic              held;

   dam_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_reset_in, strobe_in, code_in}),
      .q     ({ext_sync, strobe_sync, code_sync})
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) strobe_prev <= 1'b0;
      else        strobe_prev <= strobe_sync;

   assign strobe_rise = strobe_sync & ~strobe_prev;
   assign strobe_fall = ~strobe_sync & strobe_prev;

   dam_divider #(.BITS(DIV_BITS)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_in),
      .clr   (div_clr),
      .count (count)
   );

   assign expired   = (count >> tmo_sel) != '0;
   assign delay_met = (count >> delay_sel) != '0;

   dam_seq #(.DIGITS(DIGITS), .CODE_W(CODE_W), .STEP_W(STEP_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (ext_sync),
      .rise    (strobe_rise),
      .fall    (strobe_fall),
      .code    (code_sync),
      .prog    (prog_digits),
      .expired (expired),
      .step_q  (step_dbg),
      .held_q  (held),
      .div_clr (div_clr)
   );

   assign addr_ok = (step_dbg == DONE) & delay_met & ~expired;
endmodule

// File: rtl/dam_chk.sv
module dam_chk #(
   parameter int DIGITS = 4,
   parameter int STEP_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_ok,
   input logic [STEP_W-1:0] step_dbg,
   input logic              ext_sync,
   input logic              strobe_fall
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(DIGITS);

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (step_dbg == '0 && !addr_ok));

   p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_dbg <= LAST);

   p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dbg != $past(step_dbg) && step_dbg != '0) |-> step_dbg == $past(step_dbg) + 1'b1);

   p_adv_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dbg != '0 && step_dbg == $past(step_dbg) + 1'b1) |-> $past(strobe_fall));

   p_ok_in_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ok |-> step_dbg == LAST);

   p_leave_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(step_dbg) == LAST && step_dbg != LAST) |-> step_dbg == '0);

   p_ext_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_sync |=> step_dbg == '0);
endmodule

bind dtmf_addr_matcher dam_chk #(.DIGITS(DIGITS), .STEP_W(STEP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_ok     (addr_ok),
   .step_dbg    (step_dbg),
   .ext_sync    (ext_sync),
   .strobe_fall (strobe_fall)
);

// File: tb/dtmf_addr_matcher_test.sv
module dtmf_addr_matcher_test;
   localparam int P = 2;
   localparam logic [15:0] PROG = 16'hF0A1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_in = 1'b0;
   logic       strobe_in = 1'b0;
   logic [3:0] code_in = '0;
   logic       ext_reset_in = 1'b0;
   logic [2:0] tmo_sel = 3'd5;
   logic [2:0] delay_sel = 3'd1;
   logic       addr_ok;
   logic [2:0] step_dbg;

   int checks = 0;
   int errors = 0;

   dtmf_addr_matcher #(.DIV_BITS(8)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_in      (tick_in),
      .strobe_in    (strobe_in),
      .code_in      (code_in),
      .prog_digits  (PROG),
      .ext_reset_in (ext_reset_in),
      .tmo_sel      (tmo_sel),
      .delay_sel    (delay_sel),
      .addr_ok      (addr_ok),
      .step_dbg     (step_dbg)
   );

   initial forever #4 clk = ~clk;

   initial forever begin
      @(negedge clk) tick_in = 1'b1;
      @(negedge clk) tick_in = 1'b0;
   end

   function automatic logic [3:0] dig(input int k);
      return PROG[4*k +: 4];
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] c);
      @(negedge clk) code_in = c;
      @(negedge clk) strobe_in = 1'b1;
      repeat (4) @(negedge clk);
      strobe_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_seq();
      @(negedge clk) ext_reset_in = 1'b1;
      @(negedge clk) ext_reset_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic measure(output int hi, output int fin);
      int guard = 0;
      hi = 0;
      while (step_dbg != 3'd4 && guard < 500) begin @(negedge clk); guard++; end
      while (step_dbg == 3'd4 && guard < 5000) begin
         if (addr_ok) hi++;
         @(negedge clk);
         guard++;
      end
      fin = int'(step_dbg);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hi, fin;
      repeat (3) @(negedge clk);
      check("R1 step in reset", int'(step_dbg), 0);
      check("R1 addr_ok in reset", int'(addr_ok), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 step after reset", int'(step_dbg), 0);

      // R2: every code at the first step, only the programmed one advances
      for (int c = 0; c < 16; c++) begin
         clear_seq();
         send(4'(c));
         check("R2 first digit compare", int'(step_dbg), (4'(c) == dig(0)) ? 1 : 0);
      end

      // R3: a single flipped bit at each step position returns to step 0
      for (int k = 0; k < 4; k++)
         for (int b = 0; b < 4; b++) begin
            clear_seq();
            for (int j = 0; j < k; j++) send(dig(j));
            check("R3 prefix reached", int'(step_dbg), k);
            send(dig(k) ^ 4'(1 << b));
            check("R3 wrong bit", int'(step_dbg), 0);
         end

      // R4: no advance while the strobe is high
      clear_seq();
      @(negedge clk) code_in = dig(0);
      @(negedge clk) strobe_in = 1'b1;
      repeat (6) @(negedge clk);
      check("R4 held tone", int'(step_dbg), 0);
      strobe_in = 1'b0;
      repeat (3) @(negedge clk);
      check("R4 after fall", int'(step_dbg), 1);

      // R5: interdigit timeout with tap 3 (8 ticks = 16 clocks)
      tmo_sel = 3'd3;
      clear_seq();
      send(dig(0));
      repeat (9) @(negedge clk);
      check("R5 before timeout", int'(step_dbg), 1);
      repeat (10) @(negedge clk);
      check("R5 after timeout", int'(step_dbg), 0);

      // R6 and R7: sweep of both taps
      for (int t = 2; t <= 5; t++)
         for (int d = 0; d <= t; d++) begin
            tmo_sel = 3'(t);
            delay_sel = 3'(d);
            clear_seq();
            for (int j = 0; j < 4; j++) send(dig(j));
            check("R6 complete step", int'(step_dbg), 4);
            measure(hi, fin);
            check("R7 active time", hi, (t > d) ? ((1 << t) - (1 << d)) * P : 0);
            check("R7 back to idle", fin, 0);
         end

      // R8: strobe during the complete step is ignored
      tmo_sel = 3'd5;
      delay_sel = 3'd1;
      clear_seq();
      for (int j = 0; j < 4; j++) send(dig(j));
      fork
         measure(hi, fin);
         begin
            repeat (6) @(negedge clk);
            send(dig(0));
            check("R8 still complete", int'(step_dbg), 4);
         end
      join
      check("R8 active time unchanged", hi, 60);
      check("R8 no advance", fin, 0);

      // R9: reset request mid sequence
      clear_seq();
      send(dig(0));
      send(dig(1));
      check("R9 prefix", int'(step_dbg), 2);
      clear_seq();
      check("R9 reset mid sequence", int'(step_dbg), 0);

      // R9: reset request and matched tone end in the same cycle
      clear_seq();
      send(dig(0));
      @(negedge clk) code_in = dig(1);
      @(negedge clk) strobe_in = 1'b1;
      repeat (4) @(negedge clk);
      strobe_in = 1'b0;
      ext_reset_in = 1'b1;
      @(negedge clk) ext_reset_in = 1'b0;
      repeat (5) @(negedge clk);
      check("R9 reset wins over advance", int'(step_dbg), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule